// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver and Command Decoder

This block sits on the codec side of a serial audio link. It samples a data line and a frame-sync line on one clock edge per serial bit. From these it rebuilds a 256-bit frame made of a 16-bit tag slot followed by twelve 20-bit data slots, each sent most significant bit first. The tag slot marks which slots carry valid content. It also names the codec that a register command is meant for.

The decoder checks each frame for a register command addressed to this codec. Its codec ID comes from a static strap, and it checks that the link is reported ready. An accepted command goes to a register file as a one-cycle request that carries a read/write flag, a 7-bit index and 16 bits of write data. Playback slots flagged valid in the tag are passed on one at a time, each with its slot number and a one-cycle valid pulse.

Top module: `aclink_rx_decoder`

## Requirements
- R1: A frame starts when SYNC is sampled high after being sampled low. The data bit captured on that edge is not part of the new frame, and tag bit 15 is the bit captured on the following edge.
- R2: Tag bit positions: 15 = frame valid, 14 = slot 1 valid, 13 = slot 2 valid, 12 down to 5 = slots 3 to 10 valid, 1:0 = addressed codec ID. Each data slot is 20 bits wide and sent MSB first.
- R3: When tag bit 15 is clear, the frame produces neither a register access nor any playback output.
- R4: In slot 1, bit 19 is the access type (1 = read, 0 = write) and bits 18:12 are the register index. Slot 2 bits 19:4 are the write data. These values appear on acc_rd_o, acc_idx_o and acc_wdata_o along with the strobe.
- R5: An access is accepted only when tag bits 1:0 equal codec_id_i.
- R6: With codec_id_i = 0, a read needs tag bit 14 set, and a write needs tag bits 14 and 13 both set.
- R7: With a non-zero codec_id_i, a read or a write is accepted only when tag bits 14 and 13 are both clear.
- R8: A command whose register index has bit 0 set is dropped.
- R9: A command is dropped when codec_ready_i is low on the edge that captures the last slot-2 bit.
- R10: acc_stb_o is high for exactly one cycle, the cycle after the edge that captures the last slot-2 bit (frame bit 55).
- R11: For slot k from 3 to 10 with its tag bit set, pb_vld_o pulses for one cycle after the slot's last bit is captured, with pb_slot_o = k and pb_data_o = the slot's 20 bits. Slots 1, 2, 11 and 12 are never delivered this way.
- R12: A new SYNC rising sample in the middle of a frame abandons that frame and starts again at tag bit 15.
- R13: During and directly after reset, acc_stb_o and pb_vld_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; rising edge is the sampling edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame sync |
| sdo_i | input | 1 | Serial data from the controller |
| codec_id_i | input | 2 | Static codec ID strap |
| codec_ready_i | input | 1 | Link ready status; commands are ignored while low |
| acc_stb_o | output | 1 | One-cycle register access request |
| acc_rd_o | output | 1 | 1 = read, 0 = write |
| acc_idx_o | output | 7 | Register index |
| acc_wdata_o | output | 16 | Write data |
| pb_vld_o | output | 1 | One-cycle playback sample valid |
| pb_slot_o | output | 4 | Slot number of the playback sample |
| pb_data_o | output | 20 | Playback sample |

## Verification
The hardest case to reach from the ports is a frame that is cut short. SYNC rises again before slot 2 is complete, and a correct-looking command follows at once. If the counters did not restart, that command would be decoded out of alignment. The stimulus sends a 40-bit partial write frame and then a full frame with different contents, and it checks that only the second frame's access appears, on its expected bit position. Random frames then mix codec ID straps, tag bits, odd indices and ready states, so that every acceptance rule is exercised both ways.

// File: rtl/aclink_rx_pkg.sv
`timescale 1ns/1ps
package aclink_rx_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 16;
  localparam int ID_W   = 2;

  typedef struct packed {
    logic              rd;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata;
  } reg_cmd_t;
endpackage

// File: rtl/aclink_frame_timer.sv
`timescale 1ns/1ps
module aclink_frame_timer #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int SIDX_W    = $clog2(NUM_SLOTS + 1),
  parameter int BIDX_W    = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  output logic [SIDX_W-1:0] slot_o,
  output logic              slot_end_o
);
  logic              sync_q;
  logic              active;
  logic [SIDX_W-1:0] slot;
  logic [BIDX_W-1:0] bis;
  logic [BIDX_W-1:0] last_bit;
  logic              sync_rise;

  assign sync_rise  = sync_i & ~sync_q;
  assign last_bit   = (slot == '0) ? BIDX_W'(TAG_W - 1) : BIDX_W'(SLOT_W - 1);
  assign slot_end_o = active & ~sync_rise & (bis == last_bit);
  assign slot_o     = slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      active <= 1'b0;
      slot   <= '0;
      bis    <= '0;
    end else begin
      sync_q <= sync_i;
      if (sync_rise) begin
        active <= 1'b1;
        slot   <= '0;
        bis    <= '0;
      end else if (active) begin
        if (bis == last_bit) begin
          bis <= '0;
          if (slot == SIDX_W'(NUM_SLOTS)) active <= 1'b0;
          else                            slot   <= slot + 1'b1;
        end else begin
          bis <= bis + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aclink_slot_shifter.sv
`timescale 1ns/1ps
module aclink_slot_shifter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdo_i,
  output logic [W-1:0] word_o
);
  logic [W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[W-3:0], sdo_i};
  end

  assign word_o = {sh, sdo_i};
endmodule

// File: rtl/aclink_cmd_decode.sv
`timescale 1ns/1ps
module aclink_cmd_decode
  import aclink_rx_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int SIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_end_i,
  input  logic [SIDX_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] word_i,
  input  logic [ID_W-1:0]   codec_id_i,
  input  logic              codec_ready_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic              stb_o,
  output reg_cmd_t          cmd_o
);
  logic [TAG_W-1:0]  tag_q;
  logic [SLOT_W-1:0] s1_q;
  logic fv, v1, v2, id_hit, rd, even, tag_ok, accept;

  assign fv     = tag_q[TAG_W-1];
  assign v1     = tag_q[TAG_W-2];
  assign v2     = tag_q[TAG_W-3];
  assign id_hit = (tag_q[ID_W-1:0] == codec_id_i);
  assign rd     = s1_q[SLOT_W-1];
  assign even   = ~s1_q[SLOT_W-1-IDX_W];

  always_comb begin
    if (codec_id_i == '0) tag_ok = rd ? v1 : (v1 & v2);
    else                  tag_ok = ~v1 & ~v2;
    accept = fv & id_hit & tag_ok & even & codec_ready_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
      s1_q  <= '0;
      stb_o <= 1'b0;
      cmd_o <= '0;
    end else begin
      stb_o <= 1'b0;
      if (slot_end_i && slot_i == SIDX_W'(0)) tag_q <= word_i[TAG_W-1:0];
      if (slot_end_i && slot_i == SIDX_W'(1)) s1_q  <= word_i;
      if (slot_end_i && slot_i == SIDX_W'(2) && accept) begin
        stb_o       <= 1'b1;
        cmd_o.rd    <= rd;
        cmd_o.idx   <= s1_q[SLOT_W-2 -: IDX_W];
        cmd_o.wdata <= word_i[SLOT_W-1 -: DATA_W];
      end
    end
  end

  assign tag_o = tag_q;
endmodule

// File: rtl/aclink_pb_router.sv
`timescale 1ns/1ps
module aclink_pb_router #(
  parameter int TAG_W    = 16,
  parameter int SLOT_W   = 20,
  parameter int SIDX_W   = 4,
  parameter int PB_FIRST = 3,
  parameter int PB_LAST  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_end_i,
  input  logic [SIDX_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] word_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              vld_o,
  output logic [SIDX_W-1:0] slot_o,
  output logic [SLOT_W-1:0] data_o
);
  localparam int NSEL = 2 ** SIDX_W;
  logic [NSEL-1:0] en;
  logic            take;

  for (genvar k = 0; k < NSEL; k++) begin : g_en
    if (k >= PB_FIRST && k <= PB_LAST) begin : g_on
      assign en[k] = tag_i[TAG_W-1-k];
    end else begin : g_off
      assign en[k] = 1'b0;
    end
  end

  assign take = slot_end_i & tag_i[TAG_W-1] & en[slot_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      slot_o <= '0;
      data_o <= '0;
    end else begin
      vld_o <= take;
      if (take) begin
        slot_o <= slot_i;
        data_o <= word_i;
      end
    end
  end
endmodule

// File: rtl/aclink_rx_decoder.sv
`timescale 1ns/1ps
module aclink_rx_decoder
  import aclink_rx_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int PB_FIRST  = 3,
  parameter int PB_LAST   = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               sync_i,
  input  logic                               sdo_i,
  input  logic [ID_W-1:0]                    codec_id_i,
  input  logic                               codec_ready_i,
  output logic                               acc_stb_o,
  output logic                               acc_rd_o,
  output logic [IDX_W-1:0]                   acc_idx_o,
  output logic [DATA_W-1:0]                  acc_wdata_o,
  output logic                               pb_vld_o,
  output logic [$clog2(NUM_SLOTS+1)-1:0]     pb_slot_o,
  output logic [SLOT_W-1:0]                  pb_data_o
);
  localparam int SIDX_W = $clog2(NUM_SLOTS + 1);
  localparam int BIDX_W = $clog2(SLOT_W);

  logic [SIDX_W-1:0] slot;
  logic              slot_end;
  logic [SLOT_W-1:0] word;
  logic [TAG_W-1:0]  tag;
  reg_cmd_t          cmd;

  aclink_frame_timer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .SIDX_W(SIDX_W), .BIDX_W(BIDX_W)
  ) timer_i (
    .clk(clk), .rst(rst), .sync_i(sync_i),
    .slot_o(slot), .slot_end_o(slot_end)
  );

  aclink_slot_shifter #(.W(SLOT_W)) shift_i (
    .clk(clk), .rst(rst), .sdo_i(sdo_i), .word_o(word)
  );

  aclink_cmd_decode #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .SIDX_W(SIDX_W)
  ) dec_i (
    .clk(clk), .rst(rst), .slot_end_i(slot_end), .slot_i(slot),
    .word_i(word), .codec_id_i(codec_id_i), .codec_ready_i(codec_ready_i),
    .tag_o(tag), .stb_o(acc_stb_o), .cmd_o(cmd)
  );

  aclink_pb_router #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .SIDX_W(SIDX_W),
    .PB_FIRST(PB_FIRST), .PB_LAST(PB_LAST)
  ) pb_i (
    .clk(clk), .rst(rst), .slot_end_i(slot_end), .slot_i(slot),
    .word_i(word), .tag_i(tag),
    .vld_o(pb_vld_o), .slot_o(pb_slot_o), .data_o(pb_data_o)
  );

  assign acc_rd_o    = cmd.rd;
  assign acc_idx_o   = cmd.idx;
  assign acc_wdata_o = cmd.wdata;
endmodule

// File: rtl/aclink_rx_checker.sv
`timescale 1ns/1ps
module aclink_rx_checker #(
  parameter int SIDX_W   = 4,
  parameter int PB_FIRST = 3,
  parameter int PB_LAST  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              codec_ready_i,
  input logic              acc_stb_o,
  input logic [6:0]        acc_idx_o,
  input logic              pb_vld_o,
  input logic [SIDX_W-1:0] pb_slot_o
);
  p_stb_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    acc_stb_o |=> !acc_stb_o);

  p_even_index_r8: assert property (@(posedge clk) disable iff (rst)
    acc_stb_o |-> !acc_idx_o[0]);

  p_ready_gate_r9: assert property (@(posedge clk) disable iff (rst)
    acc_stb_o |-> $past(codec_ready_i));

  p_pb_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    pb_vld_o |=> !pb_vld_o);

  p_pb_range_r11: assert property (@(posedge clk) disable iff (rst)
    pb_vld_o |-> (pb_slot_o >= SIDX_W'(PB_FIRST) && pb_slot_o <= SIDX_W'(PB_LAST)));

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
    acc_stb_o |-> !pb_vld_o);

  p_reset_quiet_r13: assert property (@(posedge clk)
    rst |=> (!acc_stb_o && !pb_vld_o));
endmodule

bind aclink_rx_decoder aclink_rx_checker #(
  .SIDX_W($clog2(NUM_SLOTS + 1)), .PB_FIRST(PB_FIRST), .PB_LAST(PB_LAST)
) chk_i (
  .clk(clk), .rst(rst), .codec_ready_i(codec_ready_i),
  .acc_stb_o(acc_stb_o), .acc_idx_o(acc_idx_o),
  .pb_vld_o(pb_vld_o), .pb_slot_o(pb_slot_o)
);

// File: tb/aclink_rx_decoder_tb_top.sv
`timescale 1ns/1ps
module aclink_rx_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_i = 1'b0;
  logic        sdo_i = 1'b0;
  logic [1:0]  codec_id_i = 2'd0;
  logic        codec_ready_i = 1'b1;
  logic        acc_stb_o, acc_rd_o, pb_vld_o;
  logic [6:0]  acc_idx_o;
  logic [15:0] acc_wdata_o;
  logic [3:0]  pb_slot_o;
  logic [19:0] pb_data_o;

  always #2.5 clk = ~clk;

  aclink_rx_decoder dut_i (
    .clk(clk), .rst(rst), .sync_i(sync_i), .sdo_i(sdo_i),
    .codec_id_i(codec_id_i), .codec_ready_i(codec_ready_i),
    .acc_stb_o(acc_stb_o), .acc_rd_o(acc_rd_o), .acc_idx_o(acc_idx_o),
    .acc_wdata_o(acc_wdata_o), .pb_vld_o(pb_vld_o), .pb_slot_o(pb_slot_o),
    .pb_data_o(pb_data_o)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [15:0] tag;
  logic [19:0] sl [1:12];
  bit          fb [0:255];

  int          stb_n, stb_at;
  logic        stb_rd;
  logic [6:0]  stb_idx;
  logic [15:0] stb_wd;
  bit          pb_seen [0:15];
  logic [19:0] pb_dat  [0:15];
  int          pb_at   [0:15];
  int          pb_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void build();
    int p = 0;
    for (int b = 15; b >= 0; b--) begin fb[p] = tag[b]; p++; end
    for (int s = 1; s <= 12; s++)
      for (int b = 19; b >= 0; b--) begin fb[p] = sl[s][b]; p++; end
  endfunction

  task automatic sample(input int p);
    if (acc_stb_o) begin
      stb_n++; stb_at = p; stb_rd = acc_rd_o; stb_idx = acc_idx_o; stb_wd = acc_wdata_o;
    end
    if (pb_vld_o) begin
      pb_n++;
      pb_seen[pb_slot_o] = 1; pb_dat[pb_slot_o] = pb_data_o; pb_at[pb_slot_o] = p;
    end
  endtask

  task automatic send(input int nbits);
    stb_n = 0; pb_n = 0;
    for (int k = 0; k < 16; k++) pb_seen[k] = 0;
    build();
    @(negedge clk); sync_i = 1'b1; sdo_i = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sample(i);
      sync_i = (i < 16); sdo_i = fb[i];
    end
    @(negedge clk); sample(nbits); sync_i = 1'b0; sdo_i = 1'b0;
    @(negedge clk); sample(nbits + 1);
  endtask

  function automatic bit exp_acc(input logic [15:0] t, input logic [19:0] s1,
                                 input logic [1:0] id, input bit rdy);
    bit ok;
    if (id == 2'd0) ok = s1[19] ? t[14] : (t[14] & t[13]);
    else            ok = !t[14] && !t[13];
    return t[15] && (t[1:0] == id) && ok && !s1[12] && rdy;
  endfunction

  task automatic verify(input string req);
    bit e = exp_acc(tag, sl[1], codec_id_i, codec_ready_i);
    int epb = 0;
    chk(stb_n == int'(e), req, "access count", stb_n, int'(e));
    if (e && stb_n == 1) begin
      chk(stb_at == 56, "R10", "strobe bit position", stb_at, 56);
      chk(stb_rd == sl[1][19] && stb_idx == sl[1][18:12] && stb_wd == sl[2][19:4],
          "R4", "access fields", {stb_rd, stb_idx, stb_wd}, {sl[1][19], sl[1][18:12], sl[2][19:4]});
    end
    for (int k = 3; k <= 10; k++) begin
      bit ek = tag[15] && tag[15-k];
      if (ek) epb++;
      chk(pb_seen[k] == ek, "R11", $sformatf("slot %0d delivered", k), pb_seen[k], ek);
      if (ek && pb_seen[k]) begin
        chk(pb_dat[k] == sl[k], "R1", $sformatf("slot %0d data", k), pb_dat[k], sl[k]);
        chk(pb_at[k] == 16 + 20*k, "R11", $sformatf("slot %0d timing", k), pb_at[k], 16 + 20*k);
      end
    end
    chk(pb_n == epb, "R2", "playback count", pb_n, epb);
  endtask

  task automatic rnd_slots();
    for (int s = 1; s <= 12; s++) sl[s] = 20'($urandom);
  endtask

  task automatic set_cmd(input bit rd, input logic [6:0] idx, input logic [15:0] wd);
    sl[1] = {rd, idx, 12'h000};
    sl[2] = {wd, 4'h0};
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    chk(!acc_stb_o && !pb_vld_o, "R13", "outputs in reset", {acc_stb_o, pb_vld_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!acc_stb_o && !pb_vld_o, "R13", "outputs after reset", {acc_stb_o, pb_vld_o}, 0);

    // R6 primary write, all playback slots flagged (R2, R11)
    rnd_slots(); codec_id_i = 0; codec_ready_i = 1;
    tag = 16'b1111_1111_1110_0000; set_cmd(0, 7'h02, 16'hA5C3);
    send(256); verify("R6");
    // R6 primary read with slot 2 flag clear
    rnd_slots(); tag = 16'b1100_1010_1010_0000; set_cmd(1, 7'h26, 16'h0000);
    send(256); verify("R6");
    // R6 primary write missing slot 2 flag
    rnd_slots(); tag = 16'b1100_0000_0000_0000; set_cmd(0, 7'h10, 16'h1234);
    send(256); verify("R6");
    // R7 secondary accepted with both flags clear
    rnd_slots(); codec_id_i = 2; tag = 16'b1001_0000_0000_0010; set_cmd(0, 7'h18, 16'hBEEF);
    send(256); verify("R7");
    // R7 secondary rejected with slot 1 flag set
    rnd_slots(); tag = 16'b1100_0000_0000_0010; set_cmd(1, 7'h18, 16'h0);
    send(256); verify("R7");
    // R5 ID mismatch
    rnd_slots(); codec_id_i = 1; tag = 16'b1000_0000_0000_0011; set_cmd(0, 7'h04, 16'h7777);
    send(256); verify("R5");
    // R8 odd index
    rnd_slots(); codec_id_i = 0; tag = 16'b1110_0000_0000_0000; set_cmd(0, 7'h03, 16'h5555);
    send(256); verify("R8");
    // R9 not ready
    rnd_slots(); codec_ready_i = 0; tag = 16'b1110_0000_0000_0000; set_cmd(0, 7'h02, 16'h4242);
    send(256); verify("R9");
    codec_ready_i = 1;
    // R3 frame valid clear
    rnd_slots(); tag = 16'b0111_1111_1110_0000; set_cmd(0, 7'h02, 16'h9999);
    send(256); verify("R3");
    // R12 cut-short frame then a fresh frame
    rnd_slots(); tag = 16'b1110_0000_0000_0000; set_cmd(0, 7'h08, 16'hDEAD);
    send(40);
    chk(stb_n == 0, "R12", "partial frame access", stb_n, 0);
    rnd_slots(); tag = 16'b1110_0100_0000_0000; set_cmd(0, 7'h0C, 16'hC0DE);
    send(256); verify("R12");

    // Random frames
    for (int n = 0; n < 40; n++) begin
      rnd_slots();
      codec_id_i    = 2'($urandom);
      codec_ready_i = ($urandom % 8) != 0;
      tag = 16'($urandom) & 16'hFFE3;
      if ($urandom % 6 == 0) tag[15] = 0; else tag[15] = 1;
      if ($urandom % 2) tag[1:0] = codec_id_i;
      set_cmd(1'($urandom), 7'($urandom), 16'($urandom));
      send(256); verify("R6");
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule